// File: doc/BRIEF.md
# Clock Source Mode Select Controller

This block is the control plane of a multi-mode clock generator. Software writes request fields: reference choice, output clock choice, oscillator range, a low-power bit, a loop-type choice and the reference gate enables. The controller answers with status fields that move only once the hardware has actually made the change. Each clock source reports whether it is available through a ready input, so a request for a source that is not running leaves the previous selection in place. The multiplexers, oscillators and loop filters sit outside the block. They appear here only as ready and started handshakes.

The controller drives the enables of the frequency-locked loop (FLL) and phase-locked loop (PLL). It keeps a lock flag that drops on every re-lock event and rises again after a parameterised number of reference ticks. It also gates the internal and external reference outputs, which takes stop mode into account. Low-power bypass with the external reference turns both loops off and makes the range status read zero. Debug activity overrides low-power bypass, so one loop stays running.

Top module: `clkmode_ctrl`

## Requirements
- R1: After reset the status shows internal reference (`sts_ref_int`=1), output select 00 (loop output), range 0 and `lock`=0. `fll_en`=1 and `pll_en`=0 while `req_pll_sel`=0.
- R2: `sts_out_sel` takes a newly requested value only on a clock edge where that source is ready. Encodings are 00 loop (`loop_ready`), 01 internal (`int_ref_ready`) and 10 external (`ext_ref_ready`). Otherwise the old value stays.
- R3: `sts_ref_int` follows `req_ref_int` on the first edge at which the target reference is ready. That edge clears `lock`.
- R4: While `req_lowpwr`=1, changes to `req_range` are ignored. After `req_lowpwr` returns to 0, the held request is taken up.
- R5: With output select 00, a range change waits for `dco_started`. On that edge `sts_range` updates and `lock` drops. `lock` returns on the edge of the RELOCK_TICKS-th `ref_tick` and stays low after RELOCK_TICKS-1 ticks. The same counting applies after reset.
- R6: With output select 10, `req_lowpwr`=1 and `dbg_active`=0, both `fll_en` and `pll_en` are 0, `sts_range` reads 0 and `lock` falls.
- R7: While `dbg_active`=1 and `stop_req`=0, exactly one loop is enabled: `pll_en`=`req_pll_sel` and `fll_en`=!`req_pll_sel`. This holds even with `req_lowpwr`=1.
- R8: While `stop_req`=1, both loop enables are 0. `int_gate` needs `req_int_en` and, in stop, `req_int_stop_en`. `ext_gate` needs `req_ext_en` and, in stop, `req_ext_stop_en`.
- R9: At most one of the reference and output-select status fields changes per edge. A pending reference switch is taken before an output-select switch.
- R10: The code 11 on `req_out_sel` is never taken into `sts_out_sel`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_tick | input | 1 | One-cycle pulse per reference clock period |
| req_ref_int | input | 1 | Reference request, 1 = internal |
| req_out_sel | input | 2 | Output select request (00 loop, 01 internal, 10 external) |
| req_range | input | RANGE_W | Oscillator range request |
| req_lowpwr | input | 1 | Low-power request |
| req_pll_sel | input | 1 | 1 = PLL, 0 = FLL |
| req_int_en | input | 1 | Internal reference output enable |
| req_int_stop_en | input | 1 | Keep internal reference output in stop |
| req_ext_en | input | 1 | External reference output enable |
| req_ext_stop_en | input | 1 | Keep external reference output in stop |
| int_ref_ready | input | 1 | Internal reference available |
| ext_ref_ready | input | 1 | External reference available |
| loop_ready | input | 1 | Loop output available |
| dco_started | input | 1 | Oscillator at the new range has started |
| dbg_active | input | 1 | Debug session active |
| stop_req | input | 1 | Device in stop |
| sts_ref_int | output | 1 | Reference in use, 1 = internal |
| sts_out_sel | output | 2 | Output select in use |
| sts_range | output | RANGE_W | Range in use (0 in low-power external bypass) |
| fll_en | output | 1 | FLL enable |
| pll_en | output | 1 | PLL enable |
| lock | output | 1 | Loop lock indication |
| int_gate | output | 1 | Internal reference output gate |
| ext_gate | output | 1 | External reference output gate |

## Verification
The assertions check the following on every cycle:
- the loop enables under stop, debug and low-power external bypass, together with the zero range reading;
- that the status fields never change together;
- that the reserved select code never appears;
- that a new output selection only lands on a source that was ready;
- that a reference switch clears lock.

Only the bench scenarios can show the rest:
- that a range write during low power is held back and taken up later;
- that a range change waits for the oscillator start;
- the exact tick count to re-lock;
- the order in which two pending switches are taken.

// File: rtl/clkmode_pkg.sv
package clkmode_pkg;
   typedef enum logic [1:0] {
      OUT_LOOP = 2'b00,
      OUT_INT  = 2'b01,
      OUT_EXT  = 2'b10,
      OUT_RSVD = 2'b11
   } out_sel_e;
endpackage

// File: rtl/clkmode_status.sv
module clkmode_status
   import clkmode_pkg::*;
#(
   parameter int RANGE_W = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               req_ref_int,
   input  logic [1:0]         req_out_sel,
   input  logic [RANGE_W-1:0] range_lat,
   input  logic               int_ref_ready,
   input  logic               ext_ref_ready,
   input  logic               loop_ready,
   input  logic               dco_started,
   output logic               sts_ref_int,
   output logic [1:0]         sts_out_sel,
   output logic [RANGE_W-1:0] sts_range_raw,
   output logic               relock
);
   out_sel_e cur_sel, want_sel;
   logic     ref_ok, out_ok, take_ref, take_out, take_rng, engaged;

   assign cur_sel  = out_sel_e'(sts_out_sel);
   assign want_sel = out_sel_e'(req_out_sel);
   assign engaged  = (cur_sel == OUT_LOOP);
   assign ref_ok   = req_ref_int ? int_ref_ready : ext_ref_ready;

   always_comb begin
      unique case (want_sel)
         OUT_LOOP: out_ok = loop_ready;
         OUT_INT:  out_ok = int_ref_ready;
         OUT_EXT:  out_ok = ext_ref_ready;
         default:  out_ok = 1'b0;
      endcase
   end

   // one field per edge, reference switch first
   assign take_ref = (req_ref_int != sts_ref_int) && ref_ok;
   assign take_out = !take_ref && (want_sel != cur_sel) && out_ok;
   assign take_rng = !take_ref && !take_out && (range_lat != sts_range_raw)
                     && (!engaged || dco_started);
   assign relock   = take_ref || (take_rng && engaged);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sts_ref_int   <= 1'b1;
         sts_out_sel   <= OUT_LOOP;
         sts_range_raw <= '0;
      end else if (take_ref) begin
         sts_ref_int   <= req_ref_int;
      end else if (take_out) begin
         sts_out_sel   <= req_out_sel;
      end else if (take_rng) begin
         sts_range_raw <= range_lat;
      end
   end
endmodule

// File: rtl/clkmode_lock.sv
module clkmode_lock #(
   parameter int RELOCK_TICKS = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic loop_on,
   input  logic restart,
   output logic locked
);
   localparam int CW = $clog2(RELOCK_TICKS + 1);
   localparam logic [CW-1:0] FULL = CW'(RELOCK_TICKS);

   logic [CW-1:0] cnt;

   always_ff @(posedge clk) begin
      if (!rst_n)                 cnt <= '0;
      else if (restart || !loop_on) cnt <= '0;
      else if (tick && cnt != FULL) cnt <= cnt + 1'b1;
   end

   assign locked = (cnt == FULL);
endmodule

// File: rtl/clkmode_ctrl.sv
module clkmode_ctrl
   import clkmode_pkg::*;
#(
   parameter int RANGE_W      = 2,
   parameter int RELOCK_TICKS = 16,
   parameter bit GATE_REG     = 1'b0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               ref_tick,
   input  logic               req_ref_int,
   input  logic [1:0]         req_out_sel,
   input  logic [RANGE_W-1:0] req_range,
   input  logic               req_lowpwr,
   input  logic               req_pll_sel,
   input  logic               req_int_en,
   input  logic               req_int_stop_en,
   input  logic               req_ext_en,
   input  logic               req_ext_stop_en,
   input  logic               int_ref_ready,
   input  logic               ext_ref_ready,
   input  logic               loop_ready,
   input  logic               dco_started,
   input  logic               dbg_active,
   input  logic               stop_req,
   output logic               sts_ref_int,
   output logic [1:0]         sts_out_sel,
   output logic [RANGE_W-1:0] sts_range,
   output logic               fll_en,
   output logic               pll_en,
   output logic               lock,
   output logic               int_gate,
   output logic               ext_gate
);
   initial begin
      assert (RANGE_W >= 1) else $error("RANGE_W must be at least 1");
      assert (RELOCK_TICKS >= 1) else $error("RELOCK_TICKS must be at least 1");
   end

   logic [RANGE_W-1:0] range_lat, range_raw;
   logic               relock, lp_eff, bypass_lp, loop_on, int_g, ext_g;

   // range request held while low power is requested
   always_ff @(posedge clk) begin
      if (!rst_n)          range_lat <= '0;
      else if (!req_lowpwr) range_lat <= req_range;
   end

   clkmode_status #(.RANGE_W(RANGE_W)) u_status (
      .clk(clk), .rst_n(rst_n),
      .req_ref_int(req_ref_int), .req_out_sel(req_out_sel), .range_lat(range_lat),
      .int_ref_ready(int_ref_ready), .ext_ref_ready(ext_ref_ready),
      .loop_ready(loop_ready), .dco_started(dco_started),
      .sts_ref_int(sts_ref_int), .sts_out_sel(sts_out_sel),
      .sts_range_raw(range_raw), .relock(relock)
   );

   assign lp_eff    = req_lowpwr && !dbg_active;
   assign bypass_lp = lp_eff && (out_sel_e'(sts_out_sel) == OUT_EXT);
   assign loop_on   = !stop_req && !bypass_lp;
   assign fll_en    = loop_on && !req_pll_sel;
   assign pll_en    = loop_on && req_pll_sel;
   assign sts_range = bypass_lp ? '0 : range_raw;

   clkmode_lock #(.RELOCK_TICKS(RELOCK_TICKS)) u_lock (
      .clk(clk), .rst_n(rst_n), .tick(ref_tick),
      .loop_on(loop_on), .restart(relock), .locked(lock)
   );

   assign int_g = req_int_en && (!stop_req || req_int_stop_en);
   assign ext_g = req_ext_en && (!stop_req || req_ext_stop_en);

   generate
      if (GATE_REG) begin : g_gate_reg
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               int_gate <= 1'b0;
               ext_gate <= 1'b0;
            end else begin
               int_gate <= int_g;
               ext_gate <= ext_g;
            end
         end
      end else begin : g_gate_comb
         assign int_gate = int_g;
         assign ext_gate = ext_g;
      end
   endgenerate
endmodule

// File: rtl/clkmode_ctrl_chk.sv
module clkmode_ctrl_chk #(
   parameter int RANGE_W = 2
) (
   input logic               clk,
   input logic               rst_n,
   input logic               req_lowpwr,
   input logic               req_pll_sel,
   input logic               int_ref_ready,
   input logic               ext_ref_ready,
   input logic               dbg_active,
   input logic               stop_req,
   input logic               sts_ref_int,
   input logic [1:0]         sts_out_sel,
   input logic [RANGE_W-1:0] sts_range,
   input logic               fll_en,
   input logic               pll_en,
   input logic               lock
);
   assert_bypass_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (req_lowpwr && !dbg_active && sts_out_sel == 2'b10)
      |-> (!fll_en && !pll_en && sts_range == '0));

   assert_stop_loops_R8: assert property (@(posedge clk) disable iff (!rst_n)
      stop_req |-> (!fll_en && !pll_en));

   assert_debug_loop_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (dbg_active && !stop_req) |-> (pll_en == req_pll_sel && fll_en == !req_pll_sel));

   assert_one_field_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !((sts_ref_int != $past(sts_ref_int)) && (sts_out_sel != $past(sts_out_sel))));

   assert_no_rsvd_R10: assert property (@(posedge clk) disable iff (!rst_n)
      sts_out_sel != 2'b11);

   assert_ext_ready_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (sts_out_sel != $past(sts_out_sel) && sts_out_sel == 2'b10) |-> $past(ext_ref_ready));

   assert_int_ready_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (sts_out_sel != $past(sts_out_sel) && sts_out_sel == 2'b01) |-> $past(int_ref_ready));

   assert_ref_relock_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (sts_ref_int != $past(sts_ref_int)) |-> !lock);
endmodule

bind clkmode_ctrl clkmode_ctrl_chk #(.RANGE_W(RANGE_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .req_lowpwr(req_lowpwr), .req_pll_sel(req_pll_sel),
   .int_ref_ready(int_ref_ready), .ext_ref_ready(ext_ref_ready),
   .dbg_active(dbg_active), .stop_req(stop_req), .sts_ref_int(sts_ref_int),
   .sts_out_sel(sts_out_sel), .sts_range(sts_range), .fll_en(fll_en),
   .pll_en(pll_en), .lock(lock)
);

// File: tb/tb_clkmode_ctrl.sv
`timescale 1ns/1ps
module tb_clkmode_ctrl;
   localparam int RW = 2;
   localparam int NT = 16;

   logic clk = 1'b0, rst_n = 1'b0, ref_tick = 1'b0;
   logic req_ref_int = 1'b1, req_lowpwr = 1'b0, req_pll_sel = 1'b0;
   logic [1:0] req_out_sel = 2'b00;
   logic [RW-1:0] req_range = '0;
   logic req_int_en = 1'b0, req_int_stop_en = 1'b0, req_ext_en = 1'b0, req_ext_stop_en = 1'b0;
   logic int_ref_ready = 1'b0, ext_ref_ready = 1'b0, loop_ready = 1'b1, dco_started = 1'b0;
   logic dbg_active = 1'b0, stop_req = 1'b0;
   logic sts_ref_int, fll_en, pll_en, lock, int_gate, ext_gate;
   logic [1:0] sts_out_sel;
   logic [RW-1:0] sts_range;

   int checks = 0, errors = 0;

   always #5 clk = ~clk;

   clkmode_ctrl #(.RANGE_W(RW), .RELOCK_TICKS(NT)) dut (.*);

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) begin
         ref_tick = 1'b1; @(negedge clk); ref_tick = 1'b0;
      end
   endtask

   task automatic t_reset;
      chk(sts_ref_int == 1'b1, "R1 ref", sts_ref_int, 1);
      chk(sts_out_sel == 2'b00, "R1 out", sts_out_sel, 0);
      chk(sts_range == '0, "R1 range", sts_range, 0);
      chk(lock == 1'b0, "R1 lock", lock, 0);
      chk(fll_en && !pll_en, "R1 enables", {fll_en, pll_en}, 2);
   endtask

   task automatic t_lock_start;
      ticks(NT - 1);
      chk(lock == 1'b0, "R5 lock before count", lock, 0);
      ticks(1);
      chk(lock == 1'b1, "R5 lock after count", lock, 1);
   endtask

   task automatic t_ref_switch;
      req_ref_int = 1'b0;
      cyc(3);
      chk(sts_ref_int == 1'b1, "R3 held while ext not ready", sts_ref_int, 1);
      ext_ref_ready = 1'b1;
      cyc(1);
      chk(sts_ref_int == 1'b0, "R3 switched", sts_ref_int, 0);
      chk(lock == 1'b0, "R3 lock cleared", lock, 0);
      ticks(NT);
      chk(lock == 1'b1, "R3 relocked", lock, 1);
   endtask

   task automatic t_range;
      req_range = 2'd2;
      cyc(3);
      chk(sts_range == 2'd0, "R5 waits for start", sts_range, 0);
      chk(lock == 1'b1, "R5 lock kept while waiting", lock, 1);
      dco_started = 1'b1;
      cyc(1);
      chk(sts_range == 2'd2, "R5 range updated", sts_range, 2);
      chk(lock == 1'b0, "R5 lock dropped", lock, 0);
      ticks(NT - 1);
      chk(lock == 1'b0, "R5 still relocking", lock, 0);
      ticks(1);
      chk(lock == 1'b1, "R5 relocked", lock, 1);
   endtask

   task automatic t_range_lp;
      req_lowpwr = 1'b1; req_range = 2'd3;
      cyc(3);
      chk(sts_range == 2'd2, "R4 write ignored in low power", sts_range, 2);
      chk(fll_en == 1'b1, "R4 loop still on when engaged", fll_en, 1);
      req_lowpwr = 1'b0;
      cyc(2);
      chk(sts_range == 2'd3, "R4 held request taken later", sts_range, 3);
   endtask

   task automatic t_out_sel;
      req_out_sel = 2'b01;
      cyc(3);
      chk(sts_out_sel == 2'b00, "R2 int not ready keeps loop", sts_out_sel, 0);
      req_out_sel = 2'b11;
      cyc(3);
      chk(sts_out_sel == 2'b00, "R10 reserved ignored", sts_out_sel, 0);
      req_out_sel = 2'b10;
      cyc(1);
      chk(sts_out_sel == 2'b10, "R2 ext selected", sts_out_sel, 2);
   endtask

   task automatic t_bypass;
      req_lowpwr = 1'b1;
      cyc(1);
      chk(!fll_en && !pll_en, "R6 loops off", {fll_en, pll_en}, 0);
      chk(sts_range == '0, "R6 range reads zero", sts_range, 0);
      chk(lock == 1'b0, "R6 lock low", lock, 0);
   endtask

   task automatic t_debug;
      dbg_active = 1'b1;
      cyc(1);
      chk(fll_en && !pll_en, "R7 debug fll", {fll_en, pll_en}, 2);
      chk(sts_range == 2'd3, "R7 range visible again", sts_range, 3);
      req_pll_sel = 1'b1;
      cyc(1);
      chk(!fll_en && pll_en, "R7 debug pll", {fll_en, pll_en}, 1);
      dbg_active = 1'b0; req_lowpwr = 1'b0; req_pll_sel = 1'b0;
      cyc(1);
   endtask

   task automatic t_stop;
      stop_req = 1'b1; req_int_en = 1'b1; req_ext_en = 1'b1;
      cyc(1);
      chk(!fll_en && !pll_en, "R8 loops off in stop", {fll_en, pll_en}, 0);
      chk(int_gate == 1'b0, "R8 int gated without stop enable", int_gate, 0);
      chk(ext_gate == 1'b0, "R8 ext gated without stop enable", ext_gate, 0);
      req_int_stop_en = 1'b1;
      cyc(1);
      chk(int_gate == 1'b1, "R8 int kept in stop", int_gate, 1);
      chk(ext_gate == 1'b0, "R8 ext still gated", ext_gate, 0);
      stop_req = 1'b0;
      cyc(1);
      chk(ext_gate == 1'b1, "R8 ext on outside stop", ext_gate, 1);
      chk(fll_en == 1'b1, "R8 loop back after stop", fll_en, 1);
   endtask

   task automatic t_priority;
      req_ref_int = 1'b1; int_ref_ready = 1'b1; req_out_sel = 2'b01;
      cyc(1);
      chk(sts_ref_int == 1'b1, "R9 reference first", sts_ref_int, 1);
      chk(sts_out_sel == 2'b10, "R9 output waits", sts_out_sel, 2);
      cyc(1);
      chk(sts_out_sel == 2'b01, "R9 output next", sts_out_sel, 1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_lock_start();
      t_ref_switch();
      t_range();
      t_range_lp();
      t_out_sel();
      t_bypass();
      t_debug();
      t_stop();
      t_priority();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule